// File: doc/BRIEF.md
# Kernel Launch Register Window

This block is a byte-wide memory-mapped register window through which a host prepares and starts a compute kernel. The host writes a launch descriptor one byte at a time into a staging buffer. It can read that buffer back. It then writes to a doorbell location to start the launch. The data value written to the doorbell does not matter.

When the doorbell is rung, the block copies the staged grid and workgroup extents. It then computes the number of workgroups along each of the three dimensions, one dimension after another, with a shared bit-serial divider that rounds up. When the last division is done, the block pushes a single record to the dispatch queue. The record holds a fresh kernel identifier, the three per-dimension counts and their product. The block also sets a sticky active flag, which the host can read at the status location.

While the arithmetic runs, the block holds off further doorbell writes. A doorbell whose descriptor has a zero workgroup extent is rejected and raises an error flag. Accesses outside the window, or past the end of the descriptor, complete with an error response.

Top module: `kl_regwin`

## Requirements
- R1: The window covers WIN_BYTES (default 4096) bytes starting at BASE_ADDR. An access whose address lies outside the window is accepted and answered one cycle later with rsp_err=1 and rsp_rdata=0. It changes no state.
- R2: Window offsets 0 to 7 form a 64-bit status word, accessed one byte at a time. Reading offset 0 returns the active flag in bit 0, with zeros in bits 7:1. Reading offsets 1 to 7 returns 0. Writes to offsets 1 to 7 are accepted without error and have no effect.
- R3: Window offset 8+k, for k from 0 to DESC_BYTES-1 (default 16), reads and writes descriptor byte k. Each access is answered one cycle after acceptance with rsp_err=0. The descriptor bytes reset to 0.
- R4: Any accepted write to offset 0 rings the doorbell, whatever the write data. The launch uses the descriptor as staged at that moment. Descriptor fields are 16-bit little-endian. The grid extent of dimension d (x=0, y=1, z=2) sits at descriptor bytes 2d and 2d+1. The workgroup extent of dimension d sits at bytes 6+2d and 7+2d.
- R5: For each dimension, the pushed count equals ceil(grid / workgroup). A grid extent of 0 gives a count of 0.
- R6: push_total equals the product of the three pushed counts.
- R7: The first kernel identifier after reset is 0. Each later launch uses the previous identifier plus one, modulo 2^KID_W.
- R8: launch_busy rises in the cycle after a doorbell with valid extents is accepted. It stays high for 3*16+1 cycles and falls in the same cycle that push_valid is high for exactly one cycle. At that same point active is set. While launch_busy is high, req_ready is low for a doorbell write and high for every other access.
- R9: If a workgroup extent is 0 in any dimension, a doorbell sets size_err and produces no launch: no push, no busy period, no new identifier. The next doorbell with valid extents clears size_err.
- R10: An access at offset 8+DESC_BYTES or above, still inside the window, is answered with rsp_err=1 and rsp_rdata=0. It changes no descriptor byte.
- R11: After reset, launch_busy, active, size_err, push_valid and rsp_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Request accepted when req and req_ready are both high |
| rsp_valid | output | 1 | Response for the access accepted in the previous cycle |
| rsp_rdata | output | 8 | Read data byte |
| rsp_err | output | 1 | Access error |
| launch_busy | output | 1 | Workgroup count arithmetic in progress |
| active | output | 1 | Sticky flag, set by the first launch |
| size_err | output | 1 | Last doorbell had a zero workgroup extent |
| push_valid | output | 1 | One-cycle dispatch queue push |
| push_kid | output | KID_W | Kernel identifier of the push |
| push_cnt_x | output | 16 | Workgroup count, dimension x |
| push_cnt_y | output | 16 | Workgroup count, dimension y |
| push_cnt_z | output | 16 | Workgroup count, dimension z |
| push_total | output | 48 | Product of the three counts |

## Verification
On every cycle, the assertions check the following properties. Each push carries the identifier one above the previous one. The total matches the product of the counts. The fall of launch_busy coincides with a push. The active flag is set whenever a push appears. Error responses carry zero data. A size error never arises during a busy period.

Other behaviours appear only in the bench's scenarios, which compare the outputs with a behavioural model on every clock. These are the rounding-up division results for exact and inexact extents, zero grids and the widest extents. They also include the stalled doorbell during a busy period, the rejected zero-extent launch, and the error responses at the two window edges and at the descriptor end.

// File: rtl/kl_regwin.sv
module kl_regwin #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
  parameter int WIN_BYTES = 4096,
  parameter int DESC_BYTES = 16,
  parameter int KID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              rsp_err,
  output logic              launch_busy,
  output logic              active,
  output logic              size_err,
  output logic              push_valid,
  output logic [KID_W-1:0]  push_kid,
  output logic [15:0]       push_cnt_x,
  output logic [15:0]       push_cnt_y,
  output logic [15:0]       push_cnt_z,
  output logic [47:0]       push_total
);
  localparam int DIM_W = 16;
  localparam int STEP_W = $clog2(DIM_W);
  localparam int DIDX_W = $clog2(DESC_BYTES);
  localparam int TOT_W = 3 * DIM_W;

  logic [7:0] desc [DESC_BYTES];
  logic [DIM_W-1:0] gsz [3];
  logic [DIM_W-1:0] wsz [3];
  logic [DIM_W-1:0] op_g [3];
  logic [DIM_W-1:0] op_w [3];
  logic [DIM_W-1:0] cnt [3];

  for (genvar d = 0; d < 3; d++) begin : g_fld
    assign gsz[d] = {desc[2*d+1], desc[2*d]};
    assign wsz[d] = {desc[2*d+7], desc[2*d+6]};
  end

  logic [ADDR_W-1:0] rel;
  logic in_win, is_stat, is_door, is_desc, acc, door, zero_w;
  logic [DIDX_W-1:0] didx;

  assign rel     = req_addr - BASE_ADDR;
  assign in_win  = (req_addr >= BASE_ADDR) && (rel < ADDR_W'(WIN_BYTES));
  assign is_stat = in_win && (rel < ADDR_W'(8));
  assign is_door = in_win && (rel == '0);
  assign is_desc = in_win && (rel >= ADDR_W'(8)) && (rel < ADDR_W'(8 + DESC_BYTES));
  assign didx    = DIDX_W'(rel - ADDR_W'(8));
  assign req_ready = !(launch_busy && req_we && is_door);
  assign acc     = req && req_ready;
  assign door    = acc && req_we && is_door;
  assign zero_w  = (wsz[0] == '0) || (wsz[1] == '0) || (wsz[2] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < DESC_BYTES; i++) desc[i] <= '0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_err <= !(is_stat || is_desc);
        if (!req_we && is_desc)      rsp_rdata <= desc[didx];
        else if (!req_we && is_door) rsp_rdata <= {7'b0, active};
        else                         rsp_rdata <= '0;
        if (req_we && is_desc) desc[didx] <= req_wdata;
      end
    end
  end

  logic [1:0] dim;
  logic [STEP_W-1:0] step;
  logic [DIM_W-1:0] rem, quo, dvs, rem_n, quo_n, cnt_n;
  logic [DIM_W:0] shifted;
  logic ge, fin;
  logic [KID_W-1:0] kid;

  assign dvs     = (dim == 2'd0) ? op_w[0] : (dim == 2'd1) ? op_w[1] : op_w[2];
  assign shifted = {rem, quo[DIM_W-1]};
  assign ge      = shifted >= {1'b0, dvs};
  assign rem_n   = ge ? DIM_W'(shifted - {1'b0, dvs}) : shifted[DIM_W-1:0];
  assign quo_n   = {quo[DIM_W-2:0], ge};
  assign cnt_n   = quo_n + DIM_W'(rem_n != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch_busy <= 1'b0;
      active      <= 1'b0;
      size_err    <= 1'b0;
      push_valid  <= 1'b0;
      push_kid    <= '0;
      push_total  <= '0;
      kid         <= '0;
      fin         <= 1'b0;
      dim         <= '0;
      step        <= '0;
      rem         <= '0;
      quo         <= '0;
      for (int i = 0; i < 3; i++) begin
        op_g[i] <= '0;
        op_w[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      push_valid <= 1'b0;
      if (door) begin
        size_err <= zero_w;
        if (!zero_w) begin
          launch_busy <= 1'b1;
          dim  <= '0;
          step <= '0;
          rem  <= '0;
          quo  <= gsz[0];
          for (int i = 0; i < 3; i++) begin
            op_g[i] <= gsz[i];
            op_w[i] <= wsz[i];
          end
        end
      end else if (fin) begin
        fin         <= 1'b0;
        launch_busy <= 1'b0;
        push_valid  <= 1'b1;
        push_kid    <= kid;
        kid         <= kid + 1'b1;
        active      <= 1'b1;
        push_total  <= TOT_W'(cnt[0]) * TOT_W'(cnt[1]) * TOT_W'(cnt[2]);
      end else if (launch_busy) begin
        rem  <= rem_n;
        quo  <= quo_n;
        step <= step + 1'b1;
        if (step == STEP_W'(DIM_W - 1)) begin
          step <= '0;
          case (dim)
            2'd0:    cnt[0] <= cnt_n;
            2'd1:    cnt[1] <= cnt_n;
            default: cnt[2] <= cnt_n;
          endcase
          if (dim == 2'd2) fin <= 1'b1;
          else begin
            dim <= dim + 1'b1;
            rem <= '0;
            quo <= (dim == 2'd0) ? op_g[1] : op_g[2];
          end
        end
      end
    end
  end

  assign push_cnt_x = cnt[0];
  assign push_cnt_y = cnt[1];
  assign push_cnt_z = cnt[2];
endmodule

// File: rtl/kl_regwin_chk.sv
module kl_regwin_chk #(
  parameter int KID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [7:0]       rsp_rdata,
  input logic             launch_busy,
  input logic             active,
  input logic             size_err,
  input logic             push_valid,
  input logic [KID_W-1:0] push_kid,
  input logic [15:0]      push_cnt_x,
  input logic [15:0]      push_cnt_y,
  input logic [15:0]      push_cnt_z,
  input logic [47:0]      push_total
);
  logic seen;
  logic [KID_W-1:0] last_kid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      last_kid <= '0;
    end else if (push_valid) begin
      seen     <= 1'b1;
      last_kid <= push_kid;
    end
  end

  assert_kid_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && seen |-> push_kid == last_kid + 1'b1);

  assert_total_product_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> push_total == 48'(push_cnt_x) * 48'(push_cnt_y) * 48'(push_cnt_z));

  assert_busy_ends_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(launch_busy) |-> push_valid);

  assert_push_sets_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> active);

  assert_err_zero_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 8'h00);

  assert_size_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(size_err) |-> !launch_busy);
endmodule

bind kl_regwin kl_regwin_chk #(.KID_W(KID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .launch_busy(launch_busy), .active(active),
  .size_err(size_err), .push_valid(push_valid), .push_kid(push_kid),
  .push_cnt_x(push_cnt_x), .push_cnt_y(push_cnt_y), .push_cnt_z(push_cnt_z),
  .push_total(push_total));

// File: tb/kl_regwin_tb.sv
module kl_regwin_tb_top;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int LAT = 49;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = BASE;
  logic [7:0] req_wdata = 8'h00;
  logic req_ready, rsp_valid, rsp_err, launch_busy, active, size_err, push_valid;
  logic [7:0] rsp_rdata, push_kid;
  logic [15:0] push_cnt_x, push_cnt_y, push_cnt_z;
  logic [47:0] push_total;

  always #5 clk = ~clk;

  kl_regwin dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .launch_busy(launch_busy),
    .active(active), .size_err(size_err), .push_valid(push_valid),
    .push_kid(push_kid), .push_cnt_x(push_cnt_x), .push_cnt_y(push_cnt_y),
    .push_cnt_z(push_cnt_z), .push_total(push_total));

  int total = 0, bad = 0, cycles = 0;
  int m_desc [16];
  int m_cnt = 0, m_kid = 0, m_pkid = 0;
  bit m_active = 0, m_serr = 0, m_push = 0, m_rv = 0, m_rerr = 0, m_acc = 0;
  int m_rdata = 0;
  longint m_c [3];
  longint m_tot = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_ready();
    longint off = longint'(req_addr) - longint'(BASE);
    return !(m_cnt > 0 && req_we && off == 0);
  endfunction

  task automatic model_edge();
    longint off = longint'(req_addr) - longint'(BASE);
    bit inw = off >= 0 && off < 4096;
    bit isdesc = inw && off >= 8 && off < 24;
    bit isstat = inw && off < 8;
    longint g, w;
    bit zw;
    m_acc = req && model_ready();
    m_rv = m_acc;
    if (m_acc) begin
      m_rerr = !(isdesc || isstat);
      if (!req_we && isdesc) m_rdata = m_desc[off-8];
      else if (!req_we && inw && off == 0) m_rdata = int'(m_active);
      else m_rdata = 0;
    end
    m_push = 0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_push = 1; m_pkid = m_kid; m_kid = (m_kid + 1) % 256; m_active = 1;
      end
    end
    if (m_acc && req_we && isdesc) m_desc[off-8] = int'(req_wdata);
    if (m_acc && req_we && inw && off == 0) begin
      zw = 0;
      for (int d = 0; d < 3; d++)
        if (m_desc[6+2*d] + 256*m_desc[7+2*d] == 0) zw = 1;
      m_serr = zw;
      if (!zw) begin
        m_cnt = LAT;
        m_tot = 1;
        for (int d = 0; d < 3; d++) begin
          g = m_desc[2*d] + 256*m_desc[2*d+1];
          w = m_desc[6+2*d] + 256*m_desc[7+2*d];
          m_c[d] = (g + w - 1) / w;
          m_tot = m_tot * m_c[d];
        end
      end
    end
  endtask

  task automatic compare();
    chk(launch_busy == (m_cnt > 0), "R8 busy", launch_busy, m_cnt > 0);
    chk(active == m_active, "R2 active", active, m_active);
    chk(size_err == m_serr, "R9 size_err", size_err, m_serr);
    chk(push_valid == m_push, "R8 push_valid", push_valid, m_push);
    chk(rsp_valid == m_rv, "R3 rsp_valid", rsp_valid, m_rv);
    if (m_push) begin
      chk(push_kid == m_pkid[7:0], "R7 kid", push_kid, m_pkid);
      chk(push_cnt_x == m_c[0], "R5 cnt_x", push_cnt_x, m_c[0]);
      chk(push_cnt_y == m_c[1], "R5 cnt_y", push_cnt_y, m_c[1]);
      chk(push_cnt_z == m_c[2], "R5 cnt_z", push_cnt_z, m_c[2]);
      chk(push_total == m_tot, "R6 total", push_total, m_tot);
    end
    if (m_rv && rsp_valid) begin
      chk(rsp_err == m_rerr, "R1 R10 rsp_err", rsp_err, m_rerr);
      chk(rsp_rdata == m_rdata[7:0], "R2 R3 rdata", rsp_rdata, m_rdata);
    end
  endtask

  task automatic step();
    #1;
    if (req) chk(req_ready == model_ready(), "R8 req_ready", req_ready, model_ready());
    @(posedge clk);
    cycles++;
    if (rst_n) model_edge();
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic access(bit we, logic [31:0] a, logic [7:0] d, int max_wait);
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    for (int i = 0; i < max_wait; i++) begin
      step();
      if (m_acc) break;
    end
    req = 0;
  endtask

  task automatic wr(int off, int d); access(1, BASE + 32'(off), 8'(d), 1000); endtask
  task automatic rd(int off); access(0, BASE + 32'(off), 8'h00, 1000); step(); endtask
  task automatic wr16(int fbyte, int v); wr(8 + fbyte, v % 256); wr(9 + fbyte, v / 256); endtask

  task automatic setup(int gx, int gy, int gz, int wx, int wy, int wz);
    wr16(0, gx); wr16(2, gy); wr16(4, gz); wr16(6, wx); wr16(8, wy); wr16(10, wz);
  endtask

  task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_desc[i] = 0;
    for (int i = 0; i < 3; i++) m_c[i] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk(!launch_busy && !active && !size_err && !push_valid && !rsp_valid, "R11 reset",
        {launch_busy, active, size_err, push_valid, rsp_valid}, 0);
    rd(8);   // R3 descriptor resets to zero
    rd(0);   // R2 status idle
    rd(3);   // R2 upper status byte
    wr(5, 8'hFF); rd(5);   // R2 writes to upper status bytes ignored
    // R3 descriptor store
    wr(8 + 14, 8'h5A); rd(8 + 14); wr(8 + 15, 8'hC3); rd(8 + 15);
    // R1 outside window, R10 past descriptor
    access(0, BASE - 1, 8'h00, 4); step();
    access(1, BASE + 4096, 8'h77, 4); step();
    access(1, BASE + 24, 8'h11, 4); step();
    access(0, BASE + 4095, 8'h00, 4); step();
    rd(8 + 15);
    // R4 R5 launch with data ignored, inexact and exact divisions
    setup(100, 7, 1, 16, 7, 1);
    wr(0, 8'hA5);
    idle(3);
    // R8 doorbell stalled while busy, descriptor write accepted
    access(1, BASE, 8'h00, 5);
    wr(8 + 13, 8'h42); rd(8 + 13);
    idle(LAT);
    rd(0);   // R2 active now 1
    // R5 R6 R7 wide extents
    setup(65535, 1000, 3, 1, 33, 2);
    wr(0, 8'h00); idle(LAT + 2);
    // R9 zero workgroup extent rejected
    wr16(10, 0);
    wr(0, 8'h00); idle(6);
    // R9 cleared by valid launch, R5 zero grid
    setup(0, 5, 9, 4, 5, 4);
    wr(0, 8'h3C); idle(LAT + 2);
    setup(65535, 65535, 65535, 65535, 2, 65534);
    wr(0, 8'h01); idle(LAT + 2);
    done = 1;
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule